// File: doc/BRIEF.md
# Four-Bit Arithmetic/Logic Slice with Group Lookahead Outputs

This block is a purely combinational arithmetic/logic slice for two 4-bit operands. A 4-bit function code and a mode line together pick one of 32 operations. With the mode line low, the slice adds two operand-derived words plus the carry input, and the carry ripples through all four bits to a carry output. With the mode line high, the carry chain is overridden and the slice produces one of 16 bitwise functions of the operands.

The slice exports a group propagate and a group generate signal. An external second-level lookahead unit can use them to form the carries of a wide word built from many slices. Slices can also be chained directly by wiring each carry output into the next carry input.

The function code works through two per-bit terms. An "or-term" P is built from A, B and code bits 3 and 2. An "and-term" G is built from A, B and code bits 1 and 0. In arithmetic mode the result is P plus G plus the carry. In logic mode the result is the complement of P xor G.

Top module: `alu_lookahead_slice`

## Requirements
- R1: For each bit i, P_i = A_i | (B_i & S[2]) | (~B_i & S[3]) and G_i = A_i & (B_i ? S[1] : S[0]). With M = 0, {Cn4, F} equals the 5-bit sum P + G + Cn, where the carry is active high.
- R2: With M = 0 and Cn = 0: S = 0000 gives F = A; S = 0011 gives F = 2A (mod 16) with Cn4 = A[3]; S = 1100 gives F = 1111 with Cn4 = 0; S = 1111 gives F = A - 1 (mod 16).
- R3: With M = 0, S = 0110 gives {Cn4, F} = A + B + Cn. S = 1001 gives A + ~B + Cn, so Cn = 1 yields F = A - B (mod 16), with Cn4 = 1 exactly when A >= B.
- R4: With M = 1, F = ~(P ^ G) bitwise. In particular S = 0011 forces F = 1111, S = 1100 forces F = 0000, S = 0000 gives ~A, S = 1111 gives A, S = 0110 gives A xnor B and S = 1001 gives A xor B.
- R5: With M = 1, F does not depend on Cn.
- R6: GG is 1 exactly when P + G carries out of bit 3 with no carry input.
- R7: GG | PG is 1 exactly when P + G + 1 carries out of bit 3. PG is 1 exactly when all four P bits are 1.
- R8: In both modes, Cn4 = GG | (PG & Cn).
- R9: Two slices chained carry-out to carry-in with S = 0110, M = 0 give an exact 8-bit sum with carry. The lookahead term GG_hi | (PG_hi & GG_lo) | (PG_hi & PG_lo & Cn) equals the upper slice's carry output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | Operand A |
| b_i | input | 4 | Operand B |
| sel_i | input | 4 | Function code S[3:0] |
| mode_logic_i | input | 1 | M: 0 arithmetic, 1 bitwise logic |
| carry_i | input | 1 | Carry input Cn, active high |
| f_o | output | 4 | Result F |
| carry_o | output | 1 | Ripple carry output Cn4, active high |
| grp_prop_o | output | 1 | Group propagate PG |
| grp_gen_o | output | 1 | Group generate GG |

## Verification
The embedded checks are immediate assertions in combinational processes. They assume every input is a known two-state value, and they judge the outputs only once the combinational logic has settled for a given input set. The stimulus meets both assumptions: it drives all operand, code, mode and carry inputs together with defined values, then waits a fixed delay before it samples any output. The full sweep covers every input combination of one slice. A chained pair of slices is then swept over all 8-bit operand pairs, with both carry inputs, for the addition code.

// File: rtl/alu_slice_pkg.sv
// Package: shared constants for the arithmetic/logic slice.
// Assumes a 4-bit function code; the named codes are the ones whose
// results the assertions pin down.
package alu_slice_pkg;
    localparam int SEL_W = 4;

    localparam logic [SEL_W-1:0] SEL_PASS_A = 4'b0000;
    localparam logic [SEL_W-1:0] SEL_DOUBLE = 4'b0011;
    localparam logic [SEL_W-1:0] SEL_ADD    = 4'b0110;
    localparam logic [SEL_W-1:0] SEL_SUB_M1 = 4'b1001;
    localparam logic [SEL_W-1:0] SEL_ONES   = 4'b1100;
    localparam logic [SEL_W-1:0] SEL_DEC    = 4'b1111;
endpackage

// File: rtl/alu_term_gen.sv
// Module: per-bit or-term (propagate) and and-term (generate) formation.
// Bits 3/2 of the code pick which B polarity feeds the or-term and
// bits 1/0 do the same for the and-term. Assumes a 4-bit code.
module alu_term_gen
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [WIDTH-1:0] prop_o,
    output logic [WIDTH-1:0] gen_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Or-term: A, optionally widened by B or by its complement.
        assign prop_o[i] = a_i[i] | (b_i[i] & sel_i[2]) | (~b_i[i] & sel_i[3]);
        // And-term: A, masked by the code bit that matches B's value.
        assign gen_o[i]  = a_i[i] & (b_i[i] ? sel_i[1] : sel_i[0]);
    end

    // A generate bit needs A set, so it always lies inside its propagate bit.
    always_comb begin
        p_gen_in_prop_r1: assert ((gen_o & ~prop_o) == '0)
            else $error("generate bit outside propagate");
    end
endmodule

// File: rtl/alu_carry_chain.sv
// Module: ripple carry chain plus flattened group lookahead terms.
// The ripple carries feed the sum stage. The group terms are built
// separately, as a sum of products, for an external second-order
// lookahead unit. Carries are active high.
module alu_carry_chain #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] prop_i,
    input  logic [WIDTH-1:0] gen_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] carry_vec_o,
    output logic             carry_o,
    output logic             grp_prop_o,
    output logic             grp_gen_o
);
    logic [WIDTH:0] rip;

    assign rip[0] = carry_i;
    for (genvar i = 0; i < WIDTH; i++) begin : g_rip
        // Carry into the next bit: generated here or propagated from below.
        assign rip[i+1] = gen_i[i] | (prop_i[i] & rip[i]);
    end
    assign carry_vec_o = rip[WIDTH-1:0];
    assign carry_o     = rip[WIDTH];

    // Group propagate: every bit passes a carry through.
    assign grp_prop_o = &prop_i;

    // Group generate: OR of each bit's generate masked by all propagates above it.
    always_comb begin
        logic term;
        grp_gen_o = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            term = gen_i[i];
            for (int j = i + 1; j < WIDTH; j++) begin
                term = term & prop_i[j];
            end
            grp_gen_o = grp_gen_o | term;
        end
    end

    // The ripple output must agree with the lookahead form of the same carry.
    always_comb begin
        p_cout_lookahead_r8: assert (carry_o == (grp_gen_o | (grp_prop_o & carry_i)))
            else $error("ripple carry disagrees with group terms");
    end
endmodule

// File: rtl/alu_sum_stage.sv
// Module: result bits from the half-sum and the incoming carries.
// Logic mode drives every internal carry to one, which turns the sum
// into the complement of the half-sum and makes the carry input irrelevant.
module alu_sum_stage #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] prop_i,
    input  logic [WIDTH-1:0] gen_i,
    input  logic [WIDTH-1:0] carry_vec_i,
    input  logic             mode_logic_i,
    output logic [WIDTH-1:0] f_o
);
    logic [WIDTH-1:0] half_sum;
    logic [WIDTH-1:0] eff_carry;

    // Half-sum of the two terms, then the carry or the logic-mode override.
    always_comb begin
        half_sum  = prop_i ^ gen_i;
        eff_carry = carry_vec_i | {WIDTH{mode_logic_i}};
        f_o       = half_sum ^ eff_carry;
    end
endmodule

// File: rtl/alu_lookahead_slice.sv
// Module: top of the 4-bit arithmetic/logic slice.
// Purely combinational, with no clock or reset. The code and the mode
// line select one of 32 functions. The group propagate and generate
// outputs serve a second-level lookahead unit. Assumes two-state
// inputs that are settled before outputs are judged.
module alu_lookahead_slice
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             mode_logic_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] f_o,
    output logic             carry_o,
    output logic             grp_prop_o,
    output logic             grp_gen_o
);
    logic [WIDTH-1:0] prop;
    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] carry_vec;

    alu_term_gen #(.WIDTH(WIDTH)) u_terms (
        .a_i    (a_i),
        .b_i    (b_i),
        .sel_i  (sel_i),
        .prop_o (prop),
        .gen_o  (gen)
    );

    alu_carry_chain #(.WIDTH(WIDTH)) u_chain (
        .prop_i      (prop),
        .gen_i       (gen),
        .carry_i     (carry_i),
        .carry_vec_o (carry_vec),
        .carry_o     (carry_o),
        .grp_prop_o  (grp_prop_o),
        .grp_gen_o   (grp_gen_o)
    );

    alu_sum_stage #(.WIDTH(WIDTH)) u_sum (
        .prop_i       (prop),
        .gen_i        (gen),
        .carry_vec_i  (carry_vec),
        .mode_logic_i (mode_logic_i),
        .f_o          (f_o)
    );

    // Port-level checks on the named codes, evaluated once outputs settle.
    always_comb begin
        if (mode_logic_i && sel_i == SEL_DOUBLE) begin
            p_logic_ones_r4: assert (f_o == '1) else $error("logic 0011 not all ones");
        end
        if (mode_logic_i && sel_i == SEL_ONES) begin
            p_logic_zeros_r4: assert (f_o == '0) else $error("logic 1100 not all zeros");
        end
        if (!mode_logic_i && sel_i == SEL_ONES && !carry_i) begin
            p_minus_one_r2: assert (f_o == '1 && !carry_o) else $error("minus one wrong");
        end
        if (!mode_logic_i && sel_i == SEL_DOUBLE) begin
            p_double_r2: assert ({carry_o, f_o} == {a_i, carry_i}) else $error("doubling wrong");
        end
        if (!mode_logic_i && sel_i == SEL_PASS_A && !carry_i) begin
            p_pass_a_r2: assert (f_o == a_i && !carry_o) else $error("pass A wrong");
        end
    end
endmodule

// File: tb/tb_alu_lookahead_slice.sv
// Bench: exhaustive sweep of one slice against an arithmetic reference,
// then an 8-bit sweep of two slices chained by carry.
module tb_alu_lookahead_slice;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [3:0] a, b, s, f;
    logic       m, cin, cout, pg, gg;

    alu_lookahead_slice dut (
        .a_i(a), .b_i(b), .sel_i(s), .mode_logic_i(m), .carry_i(cin),
        .f_o(f), .carry_o(cout), .grp_prop_o(pg), .grp_gen_o(gg)
    );

    logic [7:0] wa, wb;
    logic       wcin;
    logic [3:0] f_lo, f_hi;
    logic       c_lo, c_hi, pg_lo, gg_lo, pg_hi, gg_hi;

    alu_lookahead_slice u_lo (
        .a_i(wa[3:0]), .b_i(wb[3:0]), .sel_i(4'b0110), .mode_logic_i(1'b0), .carry_i(wcin),
        .f_o(f_lo), .carry_o(c_lo), .grp_prop_o(pg_lo), .grp_gen_o(gg_lo)
    );
    alu_lookahead_slice u_hi (
        .a_i(wa[7:4]), .b_i(wb[7:4]), .sel_i(4'b0110), .mode_logic_i(1'b0), .carry_i(c_lo),
        .f_o(f_hi), .carry_o(c_hi), .grp_prop_o(pg_hi), .grp_gen_o(gg_hi)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (a=%0h b=%0h s=%b m=%b cin=%b)",
                     req, act, exp, a, b, s, m, cin);
        end
    endtask

    // Arithmetic reference: the two added words written per code.
    function automatic logic [4:0] ref_sum(input logic [3:0] x, y, sc, input logic c);
        logic [3:0] u, v;
        case (sc)
            4'b0000: begin u = x;       v = 4'h0;    end
            4'b0001: begin u = x;       v = x & ~y;  end
            4'b0010: begin u = x;       v = x & y;   end
            4'b0011: begin u = x;       v = x;       end
            4'b0100: begin u = x | y;   v = 4'h0;    end
            4'b0101: begin u = x | y;   v = x & ~y;  end
            4'b0110: begin u = x | y;   v = x & y;   end
            4'b0111: begin u = x | y;   v = x;       end
            4'b1000: begin u = x | ~y;  v = 4'h0;    end
            4'b1001: begin u = x | ~y;  v = x & ~y;  end
            4'b1010: begin u = x | ~y;  v = x & y;   end
            4'b1011: begin u = x | ~y;  v = x;       end
            4'b1100: begin u = 4'hF;    v = 4'h0;    end
            4'b1101: begin u = 4'hF;    v = x & ~y;  end
            4'b1110: begin u = 4'hF;    v = x & y;   end
            default: begin u = 4'hF;    v = x;       end
        endcase
        return {1'b0, u} + {1'b0, v} + {4'b0, c};
    endfunction

    // Logic reference: the 16 bitwise functions.
    function automatic logic [3:0] ref_logic(input logic [3:0] x, y, sc);
        case (sc)
            4'b0000: return ~x;
            4'b0001: return ~(x & y);
            4'b0010: return ~x | y;
            4'b0011: return 4'hF;
            4'b0100: return ~(x | y);
            4'b0101: return ~y;
            4'b0110: return ~(x ^ y);
            4'b0111: return x | ~y;
            4'b1000: return ~x & y;
            4'b1001: return x ^ y;
            4'b1010: return y;
            4'b1011: return x | y;
            4'b1100: return 4'h0;
            4'b1101: return x & ~y;
            4'b1110: return x & y;
            default: return x;
        endcase
    endfunction

    task automatic apply(input logic [3:0] ta, tb, ts, input logic tm, tc);
        a = ta; b = tb; s = ts; m = tm; cin = tc;
        #1;
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        wa = '0; wb = '0; wcin = 1'b0;
        apply(4'h0, 4'h0, 4'h0, 1'b0, 1'b0);
        #2;
        // Idle state, all inputs zero (R1).
        check("R1 idle F", {28'b0, f}, 32'h0);
        check("R1 idle carry", {31'b0, cout}, 32'h0);

        for (int ia = 0; ia < 16; ia++) begin
            for (int ib = 0; ib < 16; ib++) begin
                for (int is = 0; is < 16; is++) begin
                    for (int im = 0; im < 2; im++) begin
                        logic [3:0] f_c0;
                        for (int ic = 0; ic < 2; ic++) begin
                            logic [4:0] exp_s, s0, s1;
                            apply(4'(ia), 4'(ib), 4'(is), im[0], ic[0]);
                            exp_s = ref_sum(a, b, s, cin);
                            s0    = ref_sum(a, b, s, 1'b0);
                            s1    = ref_sum(a, b, s, 1'b1);
                            if (!m) check("R1 arith F", {28'b0, f}, {28'b0, exp_s[3:0]});
                            else    check("R4 logic F", {28'b0, f}, {28'b0, ref_logic(a, b, s)});
                            check("R8 carry out", {31'b0, cout}, {31'b0, exp_s[4]});
                            check("R6 group gen", {31'b0, gg}, {31'b0, s0[4]});
                            check("R7 group gen|prop", {31'b0, gg | pg}, {31'b0, s1[4]});
                            if (m && ic == 0) f_c0 = f;
                            if (m && ic == 1) check("R5 logic ignores carry", {28'b0, f}, {28'b0, f_c0});
                        end
                    end
                end
            end
        end

        // Directed corner codes (R2, R3, R4, R7).
        apply(4'h9, 4'h3, 4'b0011, 1'b0, 1'b0);
        check("R2 double", {27'b0, cout, f}, 32'h12);
        apply(4'h0, 4'h0, 4'b1111, 1'b0, 1'b0);
        check("R2 A minus 1 wraps", {28'b0, f}, 32'hF);
        apply(4'h6, 4'hA, 4'b1100, 1'b0, 1'b0);
        check("R2 minus one", {27'b0, cout, f}, 32'h0F);
        apply(4'h3, 4'h5, 4'b1001, 1'b0, 1'b1);
        check("R3 subtract borrow", {27'b0, cout, f}, 32'h0E);
        apply(4'h7, 4'h7, 4'b1001, 1'b0, 1'b1);
        check("R3 subtract equal", {27'b0, cout, f}, 32'h10);
        apply(4'hF, 4'h1, 4'b0110, 1'b0, 1'b1);
        check("R3 add with carry", {27'b0, cout, f}, 32'h11);
        apply(4'h5, 4'hC, 4'b1001, 1'b1, 1'b0);
        check("R4 xor", {28'b0, f}, 32'h9);
        apply(4'h0, 4'h0, 4'b1100, 1'b0, 1'b0);
        check("R7 all propagate", {31'b0, pg}, 32'h1);

        // Two chained slices over every 8-bit pair (R9).
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                for (int ic = 0; ic < 2; ic++) begin
                    logic [8:0] exp_w;
                    logic       la;
                    wa = 8'(ia); wb = 8'(ib); wcin = ic[0];
                    #1;
                    exp_w = {1'b0, wa} + {1'b0, wb} + {8'b0, wcin};
                    la    = gg_hi | (pg_hi & gg_lo) | (pg_hi & pg_lo & wcin);
                    check("R9 chained sum", {23'b0, c_hi, f_hi, f_lo}, {23'b0, exp_w});
                    check("R9 lookahead carry", {31'b0, la}, {31'b0, c_hi});
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule